// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of one priority interrupt controller. The host reaches it through a one-bit address, a write strobe with an 8-bit data byte and a read strobe with combinational read data. It owns every configuration register of the controller. These are the request mask, the vector base, the priority rotation base, and the mode flags for nested handling, automatic end-of-interrupt and rotation on automatic end-of-interrupt. It drives all of them to the priority core that sits beside it.

A write to address 0 is decoded as one of three things: a start of the initialization word sequence, a read/poll control command, or an end-of-interrupt/rotation command. Writes to address 1 feed a four-state initialization sequencer. After the sequence is complete, those writes load the mask. End-of-interrupt commands leave the in-service register itself alone. They issue a one-cycle one-hot clear pulse to the core, which holds the register. The in-service and request registers come back to this block so that it can find the highest-priority in-service level and return them on reads. A poll read returns the core's current winning level in place of a register.

Top module: `intc_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `imr`, `prio_base`, `vec_base`, `nested_mode`, `auto_eoi`, `rot_on_aeoi` and `special_mask` all clear to 0. Read-select and poll clear as well, and the sequencer goes idle, so an address-1 write then loads the mask.
- R2: An address-0 write with bit 4 set starts initialization. In the next cycle `init_clr` is high for exactly one cycle. The mask, the rotation base, the vector base, all mode flags, read-select and poll are all 0. Bit 0 of the byte records whether a fourth word will follow.
- R3: The first address-1 write after an initialization command loads `vec_base` with the byte with its three low bits forced to 0. The second address-1 write is ignored. If no fourth word was requested, the sequencer is then idle and the next address-1 write loads `imr`.
- R4: When a fourth word was requested, the third address-1 write sets `nested_mode` from bit 4 and `auto_eoi` from bit 1 and returns the sequencer to idle.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read/poll command. Bit 2 = 1 arms poll. Bit 1 = 1 loads read-select from bit 0, and bit 1 = 0 leaves read-select unchanged. Bit 6 = 1 loads `special_mask` from bit 5, and bit 6 = 0 leaves it unchanged.
- R6: An address-0 write with bits 4 and 3 both 0 carries an operation code in bits 7:5. Code 0 clears `rot_on_aeoi` and code 4 sets it.
- R7: Code 1 (non-specific end-of-interrupt) pulses `isr_clr` for one cycle with the one-hot bit of the highest-priority set in-service level. Priority runs from `prio_base` upward with wraparound. If the in-service register is empty, no pulse is issued.
- R8: Code 5 clears in the same way as code 1 and also sets `prio_base` to the cleared level + 1 mod 8. If the in-service register is empty, there is no pulse and `prio_base` is unchanged.
- R9: Code 3 pulses the clear of level data[2:0] and leaves `prio_base` unchanged. Code 6 sets `prio_base` to data[2:0] + 1 mod 8 without a clear. Code 7 pulses the clear of level data[2:0] and sets `prio_base` to that level + 1 mod 8.
- R10: Code 2 has no effect: no clear pulse, and `prio_base` and `rot_on_aeoi` are unchanged.
- R11: With poll not armed, a read of address 1 returns `imr`. A read of address 0 returns `isr_in` when read-select is 1, and `irr_in` when it is 0.
- R12: With poll armed, a read at either address returns the level on `poll_irq` (upper bits 0) when `poll_valid` is 1, and 0x07 otherwise. The read disarms poll. When `poll_valid` was 1, `poll_ack` pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data (combinational) |
| irr_in | input | 8 | Request register from the core |
| isr_in | input | 8 | In-service register from the core |
| poll_valid | input | 1 | Core has a winning request |
| poll_irq | input | 3 | Level of the winning request |
| imr | output | 8 | Request mask |
| prio_base | output | 3 | Lowest-numbered (highest priority) rotation base |
| vec_base | output | 8 | Vector base, low three bits 0 |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| init_clr | output | 1 | One-cycle pulse: clear core state and drop the output |
| isr_clr | output | 8 | One-cycle one-hot in-service clear |
| poll_ack | output | 1 | One-cycle pulse after a successful poll read |

## Verification
The bench targets the wrap of the priority search. With the base at 4 and levels 2 and 5 in service, level 5 must be cleared. A design that scans from level 0 clears level 2 instead. Both rotating codes are driven so that the new base wraps from 7 to 0; a carry that is not truncated would leave a wrong base. The bench also checks that an empty in-service register leaves both the pulse and the base untouched under codes 1 and 5, and that the read/poll command's enable bits 1 and 6 really gate their fields. It confirms that the ignored second initialization word does not leak into the mask or the mode flags, and that poll is one-shot, so that a second read returns the mask again.

// File: rtl/intc_pkg.sv
// Package: shared types and constants of the interrupt controller command decoder.
// Assumes byte-wide host access; the field positions below are fixed by the command encoding.
package intc_pkg;

    localparam int DATA_W = 8;

    // Initialization sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // operational: address 1 loads mask
        SEQ_VEC  = 2'd1,   // waiting for the vector base word
        SEQ_W3   = 2'd2,   // waiting for the ignored third word
        SEQ_W4   = 2'd3    // waiting for the mode word
    } seq_st_e;

    // Operation codes carried in bits 7:5 of an address-0 command write
    localparam logic [2:0] OP_ROT_OFF   = 3'd0;
    localparam logic [2:0] OP_EOI_HI    = 3'd1;
    localparam logic [2:0] OP_NOP       = 3'd2;
    localparam logic [2:0] OP_EOI_LVL   = 3'd3;
    localparam logic [2:0] OP_ROT_ON    = 3'd4;
    localparam logic [2:0] OP_EOI_HI_RT = 3'd5;
    localparam logic [2:0] OP_SET_BASE  = 3'd6;
    localparam logic [2:0] OP_EOI_LV_RT = 3'd7;

    // Bit positions inside an address-0 write
    localparam int B_INIT  = 4;
    localparam int B_CTRL  = 3;
    localparam int B_POLL  = 2;
    localparam int B_RSEN  = 1;
    localparam int B_RSVAL = 0;
    localparam int B_SMEN  = 6;
    localparam int B_SMVAL = 5;

    // Bit positions inside the initialization words
    localparam int B_NEED4 = 0;
    localparam int B_NEST  = 4;
    localparam int B_AEOI  = 1;

endpackage

// File: rtl/intc_init_seq.sv
// Module: intc_init_seq
// Runs the initialization word sequence shared with the mask port and holds the mask,
// vector base and the modes set by the fourth word.
// Assumes init_go and word_wr are never high together (they decode different addresses).
module intc_init_seq
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int LVL_W = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_go,
    input  logic              word_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_IRQ-1:0]  imr,
    output logic [DATA_W-1:0] vec_base,
    output logic              nested_mode,
    output logic              auto_eoi,
    output logic              init_clr
);

    seq_st_e seq_st;
    logic    need4;

    // Sequencer state, captured words and the restart pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_st      <= SEQ_IDLE;
            need4       <= 1'b0;
            imr         <= '0;
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
            init_clr    <= 1'b0;
        end else begin
            init_clr <= init_go;
            if (init_go) begin
                seq_st      <= SEQ_VEC;
                need4       <= wr_data[B_NEED4];
                imr         <= '0;
                vec_base    <= '0;
                nested_mode <= 1'b0;
                auto_eoi    <= 1'b0;
            end else if (word_wr) begin
                unique case (seq_st)
                    SEQ_IDLE: imr <= wr_data[N_IRQ-1:0];
                    SEQ_VEC: begin
                        vec_base <= {wr_data[DATA_W-1:LVL_W], {LVL_W{1'b0}}};
                        seq_st   <= SEQ_W3;
                    end
                    SEQ_W3:   seq_st <= need4 ? SEQ_W4 : SEQ_IDLE;
                    SEQ_W4: begin
                        nested_mode <= wr_data[B_NEST];
                        auto_eoi    <= wr_data[B_AEOI];
                        seq_st      <= SEQ_IDLE;
                    end
                    default:  seq_st <= SEQ_IDLE;
                endcase
            end
        end
    end

    // R2: a restart clears the mask and modes and waits for the vector word
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        init_go |=> (seq_st == SEQ_VEC) && (imr == '0) && !nested_mode && !auto_eoi && init_clr);

    // R3: the vector word is captured with its low bits forced to zero
    a_r3_vec_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && seq_st == SEQ_VEC) |=>
            (vec_base == {$past(wr_data[DATA_W-1:LVL_W]), {LVL_W{1'b0}}}) && (seq_st == SEQ_W3));

    // R3: the third word leaves the mask and modes untouched
    a_r3_w3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && seq_st == SEQ_W3) |=> $stable(imr) && $stable(nested_mode) && $stable(auto_eoi));

    // R4: the mode word sets the flags and returns to idle
    a_r4_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && seq_st == SEQ_W4) |=>
            (seq_st == SEQ_IDLE) && (nested_mode == $past(wr_data[B_NEST])) && (auto_eoi == $past(wr_data[B_AEOI])));

endmodule

// File: rtl/intc_cmd_dec.sv
// Module: intc_cmd_dec
// Decodes address-0 commands other than initialization: read/poll control and the
// end-of-interrupt / rotation operation codes. Issues one-hot in-service clear pulses
// and tracks the rotation base, read-select, poll and special mask.
// Assumes N_IRQ is a power of two so that level arithmetic wraps in LVL_W bits.
module intc_cmd_dec
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int LVL_W = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              init_go,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [N_IRQ-1:0]  isr_in,
    input  logic              poll_valid,
    output logic [LVL_W-1:0]  prio_base,
    output logic              rot_on_aeoi,
    output logic              special_mask,
    output logic              rd_isr_sel,
    output logic              poll_armed,
    output logic [N_IRQ-1:0]  isr_clr,
    output logic              poll_ack
);

    logic             ctrl_wr;
    logic             op_wr;
    logic [2:0]       op;
    logic [LVL_W-1:0] lvl_arg;
    logic             hi_found;
    logic [LVL_W-1:0] hi_lvl;

    // Classify the address-0 write
    always_comb begin
        ctrl_wr = wr0 && !wr_data[B_INIT] && wr_data[B_CTRL];
        op_wr   = wr0 && !wr_data[B_INIT] && !wr_data[B_CTRL];
        op      = wr_data[DATA_W-1:DATA_W-3];
        lvl_arg = wr_data[LVL_W-1:0];
    end

    // Find the highest-priority in-service level, scanning upward from the base
    always_comb begin
        logic [LVL_W-1:0] idx;
        hi_found = 1'b0;
        hi_lvl   = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            idx = prio_base + LVL_W'(i);
            if (!hi_found && isr_in[idx]) begin
                hi_found = 1'b1;
                hi_lvl   = idx;
            end
        end
    end

    // Command registers and single-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_base    <= '0;
            rot_on_aeoi  <= 1'b0;
            special_mask <= 1'b0;
            rd_isr_sel   <= 1'b0;
            poll_armed   <= 1'b0;
            isr_clr      <= '0;
            poll_ack     <= 1'b0;
        end else begin
            isr_clr  <= '0;
            poll_ack <= 1'b0;
            if (init_go) begin
                prio_base    <= '0;
                rot_on_aeoi  <= 1'b0;
                special_mask <= 1'b0;
                rd_isr_sel   <= 1'b0;
                poll_armed   <= 1'b0;
            end else begin
                if (rd_en && poll_armed) begin
                    poll_armed <= 1'b0;
                    poll_ack   <= poll_valid;
                end
                if (ctrl_wr) begin
                    if (wr_data[B_POLL]) poll_armed   <= 1'b1;
                    if (wr_data[B_RSEN]) rd_isr_sel   <= wr_data[B_RSVAL];
                    if (wr_data[B_SMEN]) special_mask <= wr_data[B_SMVAL];
                end
                if (op_wr) begin
                    unique case (op)
                        OP_ROT_OFF, OP_ROT_ON: rot_on_aeoi <= op[2];
                        OP_EOI_HI, OP_EOI_HI_RT: begin
                            if (hi_found) begin
                                isr_clr <= N_IRQ'(1) << hi_lvl;
                                if (op == OP_EOI_HI_RT) prio_base <= hi_lvl + LVL_W'(1);
                            end
                        end
                        OP_EOI_LVL:   isr_clr <= N_IRQ'(1) << lvl_arg;
                        OP_SET_BASE:  prio_base <= lvl_arg + LVL_W'(1);
                        OP_EOI_LV_RT: begin
                            isr_clr   <= N_IRQ'(1) << lvl_arg;
                            prio_base <= lvl_arg + LVL_W'(1);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R7: a non-specific clear only touches a single level that was in service
    a_r7_clear_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && (op == OP_EOI_HI || op == OP_EOI_HI_RT)) |=>
            ((isr_clr & ~$past(isr_in)) == '0) && $onehot0(isr_clr));

    // R8: with nothing in service the rotating clear neither pulses nor rotates
    a_r8_empty_no_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op == OP_EOI_HI_RT && isr_in == '0) |=> $stable(prio_base) && (isr_clr == '0));

    // R10: the null code changes nothing
    a_r10_null_code: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op == OP_NOP) |=> $stable(prio_base) && $stable(rot_on_aeoi) && (isr_clr == '0));

    // R12: a poll read is one-shot unless the same cycle re-arms it
    a_r12_poll_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !(ctrl_wr && wr_data[B_POLL])) |=> !poll_armed);

    // R12: the acknowledge only follows an armed read
    a_r12_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |-> $past(rd_en && poll_armed && poll_valid));

endmodule

// File: rtl/intc_rd_mux.sv
// Module: intc_rd_mux
// Selects the read data: poll result when poll is armed, otherwise mask or
// request/in-service register. Purely combinational.
module intc_rd_mux
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int LVL_W = $clog2(N_IRQ)
) (
    input  logic              addr,
    input  logic              poll_armed,
    input  logic              poll_valid,
    input  logic [LVL_W-1:0]  poll_irq,
    input  logic              rd_isr_sel,
    input  logic [N_IRQ-1:0]  imr,
    input  logic [N_IRQ-1:0]  irr_in,
    input  logic [N_IRQ-1:0]  isr_in,
    output logic [DATA_W-1:0] rd_data
);

    // Read data selection
    always_comb begin
        if (poll_armed)
            rd_data = poll_valid ? DATA_W'(poll_irq) : DATA_W'(N_IRQ - 1);
        else if (addr)
            rd_data = DATA_W'(imr);
        else if (rd_isr_sel)
            rd_data = DATA_W'(isr_in);
        else
            rd_data = DATA_W'(irr_in);
    end

endmodule

// File: rtl/intc_cmd_decoder.sv
// Module: intc_cmd_decoder (top)
// Host register interface of one interrupt controller: splits writes by address,
// runs the initialization sequencer and command decoder and muxes read data.
// Assumes single-byte accesses and that the priority core holds the request and
// in-service registers and applies the clear pulses driven from here.
module intc_cmd_decoder
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int LVL_W = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_IRQ-1:0]  irr_in,
    input  logic [N_IRQ-1:0]  isr_in,
    input  logic              poll_valid,
    input  logic [LVL_W-1:0]  poll_irq,
    output logic [N_IRQ-1:0]  imr,
    output logic [LVL_W-1:0]  prio_base,
    output logic [DATA_W-1:0] vec_base,
    output logic              nested_mode,
    output logic              auto_eoi,
    output logic              rot_on_aeoi,
    output logic              special_mask,
    output logic              init_clr,
    output logic [N_IRQ-1:0]  isr_clr,
    output logic              poll_ack
);

    logic wr0;
    logic word_wr;
    logic init_go;
    logic rd_isr_sel;
    logic poll_armed;

    // Address split of the write strobe
    always_comb begin
        wr0     = wr_en && !addr;
        word_wr = wr_en && addr;
        init_go = wr0 && wr_data[B_INIT];
    end

    intc_init_seq #(.N_IRQ(N_IRQ)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_go     (init_go),
        .word_wr     (word_wr),
        .wr_data     (wr_data),
        .imr         (imr),
        .vec_base    (vec_base),
        .nested_mode (nested_mode),
        .auto_eoi    (auto_eoi),
        .init_clr    (init_clr)
    );

    intc_cmd_dec #(.N_IRQ(N_IRQ)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr0          (wr0),
        .init_go      (init_go),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .isr_in       (isr_in),
        .poll_valid   (poll_valid),
        .prio_base    (prio_base),
        .rot_on_aeoi  (rot_on_aeoi),
        .special_mask (special_mask),
        .rd_isr_sel   (rd_isr_sel),
        .poll_armed   (poll_armed),
        .isr_clr      (isr_clr),
        .poll_ack     (poll_ack)
    );

    intc_rd_mux #(.N_IRQ(N_IRQ)) u_mux (
        .addr       (addr),
        .poll_armed (poll_armed),
        .poll_valid (poll_valid),
        .poll_irq   (poll_irq),
        .rd_isr_sel (rd_isr_sel),
        .imr        (imr),
        .irr_in     (irr_in),
        .isr_in     (isr_in),
        .rd_data    (rd_data)
    );

endmodule

// File: tb/intc_cmd_decoder_tb.sv
// Directed bench for intc_cmd_decoder: one task per scenario, each checking its results.
module intc_cmd_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] irr_in = '0;
    logic [7:0] isr_in = '0;
    logic       poll_valid = 1'b0;
    logic [2:0] poll_irq = '0;
    logic [7:0] imr;
    logic [2:0] prio_base;
    logic [7:0] vec_base;
    logic       nested_mode, auto_eoi, rot_on_aeoi, special_mask, init_clr, poll_ack;
    logic [7:0] isr_clr;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    intc_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irr_in(irr_in), .isr_in(isr_in),
        .poll_valid(poll_valid), .poll_irq(poll_irq), .imr(imr), .prio_base(prio_base),
        .vec_base(vec_base), .nested_mode(nested_mode), .auto_eoi(auto_eoi),
        .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask), .init_clr(init_clr),
        .isr_clr(isr_clr), .poll_ack(poll_ack)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Write one byte; returns at the negedge after the capturing edge
    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read one byte; data sampled before the edge, returns at the following negedge
    task automatic rd(logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 imr", imr, 8'h00);
        chk("R1 base", prio_base, 3'd0);
        chk("R1 vec", vec_base, 8'h00);
        chk("R1 flags", {nested_mode, auto_eoi, rot_on_aeoi, special_mask}, 4'b0000);
        irr_in = 8'h5A; isr_in = 8'hC3;
        rd(1'b0, d);
        chk("R1 R11 read-select clear gives irr", d, 8'h5A);
        wr(1'b1, 8'h33);
        chk("R1 idle sequencer loads mask", imr, 8'h33);
        rd(1'b1, d);
        chk("R11 addr1 reads mask", d, 8'h33);
    endtask

    task automatic t_init_three();
        wr(1'b0, 8'h10);
        chk("R2 init_clr pulse", init_clr, 1'b1);
        chk("R2 mask cleared", imr, 8'h00);
        @(negedge clk);
        chk("R2 init_clr single cycle", init_clr, 1'b0);
        wr(1'b1, 8'h6F);
        chk("R3 vector base low bits zero", vec_base, 8'h68);
        wr(1'b1, 8'hFF);
        chk("R3 third word ignored mask", imr, 8'h00);
        chk("R3 third word ignored modes", {nested_mode, auto_eoi}, 2'b00);
        wr(1'b1, 8'hA5);
        chk("R3 back to mask load", imr, 8'hA5);
        chk("R3 vector kept", vec_base, 8'h68);
    endtask

    task automatic t_init_four();
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'hC3);
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h11);
        chk("R2 clears rotate flag", rot_on_aeoi, 1'b0);
        chk("R2 clears base", prio_base, 3'd0);
        chk("R2 clears special mask", special_mask, 1'b0);
        chk("R2 clears vector", vec_base, 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h12);
        chk("R4 nested mode", nested_mode, 1'b1);
        chk("R4 auto eoi", auto_eoi, 1'b1);
        wr(1'b1, 8'h0F);
        chk("R4 idle after fourth word", imr, 8'h0F);
        chk("R4 modes kept", {nested_mode, auto_eoi}, 2'b11);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        chk("R4 only auto eoi", {nested_mode, auto_eoi}, 2'b01);
    endtask

    task automatic t_ctrl_cmd();
        logic [7:0] d;
        irr_in = 8'h18; isr_in = 8'h81;
        rd(1'b0, d);
        chk("R2 read-select cleared by init", d, 8'h18);
        wr(1'b0, 8'h0B);
        rd(1'b0, d);
        chk("R5 R11 read-select set gives isr", d, 8'h81);
        wr(1'b0, 8'h08);
        rd(1'b0, d);
        chk("R5 read-select held without enable", d, 8'h81);
        wr(1'b0, 8'h0A);
        rd(1'b0, d);
        chk("R5 read-select cleared", d, 8'h18);
        wr(1'b0, 8'h68);
        chk("R5 special mask set", special_mask, 1'b1);
        wr(1'b0, 8'h28);
        chk("R5 special mask held without enable", special_mask, 1'b1);
        wr(1'b0, 8'h48);
        chk("R5 special mask cleared", special_mask, 1'b0);
    endtask

    task automatic t_poll();
        logic [7:0] d;
        wr(1'b1, 8'h5C);
        poll_valid = 1'b1; poll_irq = 3'd5;
        wr(1'b0, 8'h0C);
        rd(1'b1, d);
        chk("R12 poll returns level", d, 8'h05);
        chk("R12 poll_ack pulse", poll_ack, 1'b1);
        rd(1'b1, d);
        chk("R12 poll disarmed", d, 8'h5C);
        chk("R12 no ack unarmed", poll_ack, 1'b0);
        poll_valid = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b0, d);
        chk("R12 empty poll returns 7", d, 8'h07);
        chk("R12 no ack when empty", poll_ack, 1'b0);
    endtask

    task automatic t_eoi_hi();
        isr_in = 8'h24;
        wr(1'b0, 8'h20);
        chk("R7 clear highest level from base 0", isr_clr, 8'h04);
        @(negedge clk);
        chk("R7 pulse single cycle", isr_clr, 8'h00);
        isr_in = 8'h00;
        wr(1'b0, 8'h20);
        chk("R7 empty isr no pulse", isr_clr, 8'h00);
        wr(1'b0, 8'hC3);
        chk("R9 set base code 6", prio_base, 3'd4);
        isr_in = 8'h24;
        wr(1'b0, 8'h20);
        chk("R7 scan wraps from base 4", isr_clr, 8'h20);
        chk("R7 base unchanged", prio_base, 3'd4);
        wr(1'b0, 8'hA0);
        chk("R8 rotating clear", isr_clr, 8'h20);
        chk("R8 base follows cleared level", prio_base, 3'd6);
        isr_in = 8'h00;
        wr(1'b0, 8'hA0);
        chk("R8 empty no pulse", isr_clr, 8'h00);
        chk("R8 empty no rotate", prio_base, 3'd6);
        isr_in = 8'h80;
        wr(1'b0, 8'hA0);
        chk("R8 base wraps to 0", prio_base, 3'd0);
    endtask

    task automatic t_eoi_lvl();
        wr(1'b0, 8'hC1);
        wr(1'b0, 8'h66);
        chk("R9 specific clear", isr_clr, 8'h40);
        chk("R9 specific keeps base", prio_base, 3'd2);
        wr(1'b0, 8'hE7);
        chk("R9 rotating specific clear", isr_clr, 8'h80);
        chk("R9 rotating specific base wraps", prio_base, 3'd0);
        wr(1'b0, 8'hC7);
        chk("R9 set base wraps", prio_base, 3'd0);
        chk("R9 set base no clear", isr_clr, 8'h00);
    endtask

    task automatic t_rot_and_null();
        wr(1'b0, 8'h80);
        chk("R6 code 4 sets rotate", rot_on_aeoi, 1'b1);
        wr(1'b0, 8'hC2);
        isr_in = 8'hFF;
        wr(1'b0, 8'h45);
        chk("R10 null keeps base", prio_base, 3'd3);
        chk("R10 null keeps rotate", rot_on_aeoi, 1'b1);
        chk("R10 null no clear", isr_clr, 8'h00);
        wr(1'b0, 8'h00);
        chk("R6 code 0 clears rotate", rot_on_aeoi, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_three();
        t_init_four();
        t_ctrl_cmd();
        t_poll();
        t_eoi_hi();
        t_eoi_lvl();
        t_rot_and_null();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule